// File: doc/BRIEF.md
# Multi-Mode Synchronous Serial Port

This block is one channel of a synchronous serial port that always acts as clock master. A single control register selects how the two data pins are used: a half-duplex link on pin 0, full duplex (transmit on pin 0 and receive on pin 1), half-duplex on pin 1 alone, or full duplex with channel-select supervision. The same register sets the idle level of the serial clock and which of its two edges launches data and which samples it. A divisor register sets the clock rate. Writing a byte to the transmit-start or receive-start address runs one transfer of `DW` bits, most significant bit first, and raises a done flag and the interrupt pending output when the last bit has been handled.

In the two channel-select modes the port watches an active-low select line that another master pulls low when it wants the clock. The line passes through a two-stage synchronizer, and its falling edge sets a sticky contention flag in the control register. An enable bit decides whether the event also raises the interrupt pending output. In the other modes the line is ignored.

Register map (`wr_addr`): 0 control, 1 divisor, 2 start a transmit, 3 start a receive. Control bits: [5:4] mode, [3] contention interrupt enable, [2] contention pending, [1] phase, [0] polarity, [7:6] reserved.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control register reads 0x00, the port is idle, `sclk` is low, and `done`, `irq`, both output enables and `rx_data` are 0.
- R2: A control write stores bits [5:0]. Bits [7:6] always read as 0. The value becomes visible on `ctrl_q` one clock after the write.
- R3: Pin usage by mode (control bits [5:4]): 00 drives `dq0` on a transmit and samples `dq0_i` on a receive. 10 does the same on `dq1`. 01 and 11 drive `dq0` and sample `dq1_i` on every transfer. A pin's output enable is high only during a transfer that drives it, and the two enables are never high together.
- R4: When idle, `sclk` equals the polarity bit (bit 0). A transfer makes 2·DW clock edges, each (divisor+1) system clocks after the previous one, with the first edge (divisor+1) clocks after the start write, and it ends at the idle level.
- R5: With the phase bit (bit 1) at 0, the MSB is on the data pin from the start, the input is sampled on the first (leading) edge of each clock period, and the output changes on the trailing edges. With the phase bit at 1, the output changes on leading edges and the input is sampled on trailing edges. Data goes MSB first.
- R6: On the last clock edge `busy` falls and `done` and `irq` rise. `rx_data` takes the received byte if the transfer received (receive start, or mode 01/11). `done` stays set until the next start.
- R7: In modes 10 and 11, a falling edge on `csel_n` sets the contention pending bit (bit 2) on the third rising clock edge after it is first sampled low.
- R8: When the contention interrupt enable (bit 3) is 1, a contention event also sets `irq`. When it is 0, only bit 2 is set. In modes 00 and 01, `csel_n` sets neither.
- R9: Writing 0 to bit 2 clears the contention pending bit. Writing 1 leaves it as it was. An event in the same clock keeps it set.
- R10: While busy, start writes, divisor writes, and control writes to mode, phase and polarity are ignored. Bits 3 and 2 are still written.
- R11: `irq_ack` clears `irq` unless a new cause sets it in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 divisor, 2 transmit start, 3 receive start |
| wr_data | input | DW | Write data |
| irq_ack | input | 1 | Clears the interrupt pending output |
| ctrl_q | output | 8 | Control register readback |
| rx_data | output | DW | Last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished |
| irq | output | 1 | Channel interrupt pending |
| sclk | output | 1 | Serial clock |
| dq0_o | output | 1 | Data pin 0 output value |
| dq0_oe | output | 1 | Data pin 0 output enable |
| dq0_i | input | 1 | Data pin 0 input |
| dq1_o | output | 1 | Data pin 1 output value |
| dq1_oe | output | 1 | Data pin 1 output enable |
| dq1_i | input | 1 | Data pin 1 input |
| csel_n | input | 1 | Active-low channel-select request from another master |

## Verification
The bench builds the port with its default 8-bit data and 8-bit divisor. It programs divisors of 0, 1 and 3, so every mode, phase and polarity combination runs in both directions, including the fastest case where the clock toggles on every system clock. The small divisors keep transfers short, so reconfiguration attempts in the middle of a transfer, contention pulses during a transfer, and contention flag clears can all be timed against a per-cycle reference in a few thousand cycles.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          irq_ack,
  output logic [7:0]    ctrl_q,
  output logic [DW-1:0] rx_data,
  output logic          busy,
  output logic          done,
  output logic          irq,
  output logic          sclk,
  output logic          dq0_o,
  output logic          dq0_oe,
  input  logic          dq0_i,
  output logic          dq1_o,
  output logic          dq1_oe,
  input  logic          dq1_i,
  input  logic          csel_n
);
  localparam int EDGES = 2 * DW;
  localparam int EW    = $clog2(EDGES);

  logic [1:0]       mode_q;
  logic             conint_q, conpnd_q, ph_q, pol_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [EW-1:0]    edge_q;
  logic             busy_q, done_q, irq_q, tgl_q, out_q, rxdir_q;
  logic [DW-1:0]    tx_q, rx_q, rxd_q;
  logic [2:0]       sync_q;

  logic wr_ctrl, wr_div, start, tick, lead, samp, shft, fin, rx_pin, ev, rx_en;
  logic [DW-1:0] rx_nxt;

  assign wr_ctrl = wr_en && wr_addr == 2'd0;
  assign wr_div  = wr_en && wr_addr == 2'd1;
  assign start   = wr_en && wr_addr[1] && !busy_q;
  assign tick    = busy_q && cnt_q == div_q;
  assign lead    = ~edge_q[0];
  assign samp    = tick && (lead ^ ph_q);
  assign shft    = tick && !(lead ^ ph_q);
  assign fin     = tick && edge_q == EW'(EDGES - 1);
  assign rx_pin  = (mode_q == 2'b00) ? dq0_i : dq1_i;
  assign rx_nxt  = {rx_q[DW-2:0], rx_pin};
  assign ev      = mode_q[1] && sync_q[2] && !sync_q[1];
  assign rx_en   = rxdir_q || mode_q[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[1:0], csel_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      conint_q <= 1'b0;
      conpnd_q <= 1'b0;
      ph_q     <= 1'b0;
      pol_q    <= 1'b0;
      div_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        conint_q <= wr_data[3];
        if (!busy_q) begin
          mode_q <= wr_data[5:4];
          ph_q   <= wr_data[1];
          pol_q  <= wr_data[0];
        end
      end
      conpnd_q <= (wr_ctrl ? (conpnd_q & wr_data[2]) : conpnd_q) | ev;
      if (wr_div && !busy_q) div_q <= wr_data[DIV_W-1:0];
      if (fin || (ev && conint_q)) irq_q <= 1'b1;
      else if (irq_ack)            irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      edge_q  <= '0;
      tgl_q   <= 1'b0;
      out_q   <= 1'b0;
      rxdir_q <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      rxd_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      edge_q  <= '0;
      tgl_q   <= 1'b0;
      rxdir_q <= wr_addr[0];
      out_q   <= wr_data[DW-1];
      tx_q    <= ph_q ? wr_data : {wr_data[DW-2:0], 1'b0};
      rx_q    <= '0;
    end else if (busy_q) begin
      if (tick) begin
        cnt_q  <= '0;
        edge_q <= edge_q + 1'b1;
        tgl_q  <= ~tgl_q;
        if (samp) rx_q <= rx_nxt;
        if (shft) begin
          out_q <= tx_q[DW-1];
          tx_q  <= {tx_q[DW-2:0], 1'b0};
        end
        if (fin) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (rx_en) rxd_q <= samp ? rx_nxt : rx_q;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ctrl_q  = {2'b00, mode_q, conint_q, conpnd_q, ph_q, pol_q};
  assign rx_data = rxd_q;
  assign busy    = busy_q;
  assign done    = done_q;
  assign irq     = irq_q;
  assign sclk    = pol_q ^ tgl_q;
  assign dq0_o   = out_q;
  assign dq1_o   = out_q;
  assign dq0_oe  = busy_q && (mode_q[0] || (mode_q == 2'b00 && !rxdir_q));
  assign dq1_oe  = busy_q && mode_q == 2'b10 && !rxdir_q;

  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(dq0_oe && dq1_oe)); // R3
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> sclk == pol_q); // R4
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(done_q) |-> irq_q); // R6
  AST_CONPND_SET: assert property (@(posedge clk) disable iff (!rst_n) ev |=> conpnd_q); // R7
  AST_CONPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conpnd_q && !(wr_ctrl && !wr_data[2])) |=> conpnd_q); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> ($stable(mode_q) && $stable(div_q) && $stable(ph_q))); // R10
endmodule

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       irq_ack = 1'b0;
  logic       csel_n = 1'b1;
  logic       dq0_i, dq1_i;
  logic [7:0] ctrl_q, rx_data;
  logic       busy, done, irq, sclk, dq0_o, dq0_oe, dq1_o, dq1_oe;

  always #5 clk = ~clk;

  sync_serial_port #(.DW(8), .DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_ack(irq_ack), .ctrl_q(ctrl_q), .rx_data(rx_data), .busy(busy), .done(done),
    .irq(irq), .sclk(sclk), .dq0_o(dq0_o), .dq0_oe(dq0_oe), .dq0_i(dq0_i),
    .dq1_o(dq1_o), .dq1_oe(dq1_oe), .dq1_i(dq1_i), .csel_n(csel_n));

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [1:0] m_mode, o_mode;
  logic m_ci, m_cp, m_ph, m_pol, m_busy, m_done, m_irq, m_out, m_rxdir;
  logic o_busy, o_ci, ev, fin, lead;
  logic [7:0] m_tx, m_rx, m_rxd, m_div;
  logic [2:0] m_s;
  int m_c, m_edges, m_ns, k;
  logic [7:0] sl0, sl1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ci = 0; m_cp = 0; m_ph = 0; m_pol = 0; m_busy = 0; m_done = 0;
      m_irq = 0; m_out = 0; m_rxdir = 0; m_tx = 0; m_rx = 0; m_rxd = 0; m_div = 0;
      m_s = 3'b111; m_c = 0; m_edges = 0; m_ns = 0;
    end else begin
      o_busy = m_busy; o_ci = m_ci; o_mode = m_mode;
      ev = o_mode[1] && m_s[2] && !m_s[1];
      m_s = {m_s[1:0], csel_n};
      fin = 0;
      if (o_busy) begin
        m_c++;
        if (m_c % (int'(m_div) + 1) == 0) begin
          k = m_c / (int'(m_div) + 1) - 1;
          lead = (k % 2 == 0);
          if (lead != m_ph) begin
            m_rx = {m_rx[6:0], (o_mode == 2'b00) ? dq0_i : dq1_i};
            m_ns++;
          end else if (!m_ph) begin
            if ((k + 1) / 2 <= 7) m_out = m_tx[7 - (k + 1) / 2];
          end else begin
            m_out = m_tx[7 - k / 2];
          end
          m_edges = k + 1;
          if (k == 15) begin
            fin = 1; m_busy = 0; m_done = 1;
            if (m_rxdir || o_mode[0]) m_rxd = m_rx;
          end
        end
      end
      if (wr_en) begin
        if (wr_addr == 2'd0) begin
          m_ci = wr_data[3];
          m_cp = m_cp & wr_data[2];
          if (!o_busy) begin m_mode = wr_data[5:4]; m_ph = wr_data[1]; m_pol = wr_data[0]; end
        end else if (wr_addr == 2'd1) begin
          if (!o_busy) m_div = wr_data;
        end else if (!o_busy) begin
          m_busy = 1; m_c = 0; m_edges = 0; m_tx = wr_data; m_out = wr_data[7];
          m_done = 0; m_rxdir = wr_addr[0]; m_rx = 0; m_ns = 0;
        end
      end
      if (ev) m_cp = 1;
      if (fin || (ev && o_ci)) m_irq = 1;
      else if (irq_ack) m_irq = 0;
    end
  end

  logic e0, e1;
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      chk("R2 R7 R9 R10 ctrl_q", ctrl_q, {2'b00, m_mode, m_ci, m_cp, m_ph, m_pol});
      chk("R6 R10 busy", busy, m_busy);
      chk("R6 done", done, m_done);
      chk("R8 R11 irq", irq, m_irq);
      chk("R4 sclk", sclk, m_pol ^ m_edges[0]);
      e0 = m_busy && (m_mode[0] || (m_mode == 2'b00 && !m_rxdir));
      e1 = m_busy && m_mode == 2'b10 && !m_rxdir;
      chk("R3 dq0_oe", dq0_oe, e0);
      chk("R3 dq1_oe", dq1_oe, e1);
      if (e0) chk("R5 dq0_o", dq0_o, m_out);
      if (e1) chk("R5 dq1_o", dq1_o, m_out);
      chk("R3 R5 R6 rx_data", rx_data, m_rxd);
    end
    dq0_i = (m_ns < 8) ? sl0[7 - m_ns] : 1'b0;
    dq1_i = (m_ns < 8) ? sl1[7 - m_ns] : 1'b0;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_sel(input int len);
    @(negedge clk); csel_n = 1'b0;
    repeat (len) @(negedge clk);
    csel_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] divs [3];
    divs[0] = 8'd0; divs[1] = 8'd1; divs[2] = 8'd3;
    sl0 = 8'h00; sl1 = 8'h00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ctrl reset", ctrl_q, 8'h00);
    chk("R1 busy reset", busy, 1'b0);
    chk("R1 flags reset", {done, irq, dq0_oe, dq1_oe}, 4'b0000);
    chk("R1 sclk reset", sclk, 1'b0);
    chk("R1 rx reset", rx_data, 8'h00);

    wr(2'd0, 8'hFF);                       // R2: reads 0x3B
    @(negedge clk);
    chk("R2 reserved bits", ctrl_q, 8'h3B);
    wr(2'd0, 8'h00);

    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 4; p++)
        for (int dir = 0; dir < 2; dir++) begin
          sl0 = 8'h3C + 8'(m * 8 + p * 2 + dir);
          sl1 = 8'hC6 ^ 8'(m * 16 + p * 4 + dir);
          wr(2'd0, {2'b00, 2'(m), 2'b00, 2'(p)});
          wr(2'd1, divs[(m + p + dir) % 3]);
          wr({1'b1, 1'(dir)}, 8'hA5 ^ 8'(m * 37 + p * 11 + dir));
          wait_idle();
          ack();
        end

    // R10: reconfiguration attempts during a transfer
    wr(2'd0, 8'h00); wr(2'd1, 8'd3);
    sl0 = 8'h96;
    wr(2'd2, 8'h5A);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h1B);
    wr(2'd3, 8'hFF);
    wait_idle();
    chk("R10 mode frozen", ctrl_q[5:0], 6'h08);
    ack();

    // R7 R8: contention with interrupt routing in mode 10
    wr(2'd0, 8'h28);
    pulse_sel(3);
    chk("R7 pending set", ctrl_q[2], 1'b1);
    chk("R8 irq routed", irq, 1'b1);
    wr(2'd0, 8'h2C);                       // R9: writing 1 keeps it
    chk("R9 write one", ctrl_q[2], 1'b1);
    wr(2'd0, 8'h20);                       // R9: writing 0 clears it
    chk("R9 write zero", ctrl_q[2], 1'b0);
    ack();
    chk("R11 ack", irq, 1'b0);
    pulse_sel(2);                          // R8: enable off
    chk("R8 pending only", {ctrl_q[2], irq}, 2'b10);
    wr(2'd0, 8'h08);                       // mode 00, clears pending
    pulse_sel(4);                          // R8: ignored outside channel-select
    chk("R8 std ignored", {ctrl_q[2], irq}, 2'b00);
    wr(2'd0, 8'h18);
    pulse_sel(4);
    chk("R8 duplex ignored", {ctrl_q[2], irq}, 2'b00);

    // contention during a transfer in mode 11
    wr(2'd0, 8'h39); wr(2'd1, 8'd1);
    sl1 = 8'h71;
    wr(2'd2, 8'hC3);
    pulse_sel(2);
    wait_idle();
    chk("R7 pending in transfer", ctrl_q[2], 1'b1);
    chk("R6 duplex rx", rx_data, 8'h71);
    ack();
    // clear racing a new event
    @(negedge clk); csel_n = 1'b0;
    @(negedge clk);
    wr(2'd0, 8'h38);
    csel_n = 1'b1;
    repeat (6) @(negedge clk);
    ack();
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule